// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block applies the status rules of a host controller's transfer descriptor. For each finished bus transaction it takes the descriptor's 32-bit control word and 32-bit token, plus the outcome the transaction issuer reported. That outcome is data accepted with a byte count, NAK, stall, no device (timeout), or babble. The block returns the rewritten control word and a flag that says whether the word must be written back to memory. It also returns the interrupt causes the frame must gather, a process-error flag, an error-interrupt flag, and a verdict. The verdict tells the list walker to advance (success), to move to the next queue entry (skip), or to stop the frame (abort).

The same token is also decoded into the packet identifier, device address, endpoint and maximum transfer length, so the transaction issuer can form the bus packet. Memory access, data movement and the bus transaction are handled elsewhere.

Results appear one clock after `in_valid` and are qualified by `out_valid` (parameter `REG_OUT` = 1). With `REG_OUT` = 0 the same logic drives the outputs combinationally.

Top module: `td_status_update`

## Requirements
- R1: The token decodes as follows: PID = bits 7:0, device address = bits 14:8, endpoint = bits 18:15. Maximum length = (bits 31:21 + 1) kept to 11 bits, so a field of 0x7FF gives 0. Only PIDs 0x2D (setup), 0x69 (in) and 0xE1 (out) are valid.
- R2: Control bit 24 (interrupt on complete) sets cause bit 0 whatever the outcome or the active state. If active (bit 23) is clear, the word is returned unchanged with verdict skip (code 1), and no other cause or flag is set.
- R3: An active descriptor with an invalid PID raises process error and gives verdict abort (code 2), with the control word unchanged.
- R4: On data accepted (outcome code 0), bits 10:0 become (length − 1) kept to 11 bits and active is cleared. Length is the maximum for setup and out, and the returned count for in. The verdict is success (code 0) unless R5 applies.
- R5: An in transfer that succeeds with short-packet detect (bit 29) set and a length below the maximum sets cause bit 1 and gives verdict skip.
- R6: An in transfer whose returned count exceeds the maximum is handled as babble (R10).
- R7: No device (outcome code 3, and unused codes 5 to 7) sets timeout (bit 18). A non-zero error counter (bits 28:27) is decremented. When the decrement reaches zero, active is cleared and the error interrupt is flagged. A counter that is already zero stays zero. The verdict is skip.
- R8: NAK (outcome code 1) sets bit 19 and gives skip. On a setup PID it then also follows R7.
- R9: Stall (outcome code 2) sets bit 22, clears active and gives skip.
- R10: Babble (outcome code 4) sets bits 20 and 22, clears active and gives abort.
- R11: For an active, valid-PID descriptor, isochronous select (bit 25) clears active whatever the outcome.
- R12: The write-back flag is high exactly when the returned control word differs from the input word.
- R13: After reset all outputs are zero. With `REG_OUT` = 1, every result appears exactly one cycle after its `in_valid`, and `out_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor and outcome are present |
| in_ctrl | input | 32 | Descriptor control word |
| in_token | input | 32 | Descriptor token word |
| in_outcome | input | 3 | Transaction outcome code |
| in_count | input | CNT_W | Bytes returned by an in transfer |
| out_valid | output | 1 | Result is present |
| out_ctrl | output | 32 | Rewritten control word |
| out_wb_need | output | 1 | Control word changed and must be stored |
| out_cause | output | 2 | Interrupt causes: bit 0 completion, bit 1 short packet |
| out_perr | output | 1 | Invalid PID seen |
| out_err_irq | output | 1 | Error counter expired |
| out_verdict | output | 2 | 0 success, 1 skip, 2 abort |
| out_pid | output | 8 | Decoded PID |
| out_dev_addr | output | 7 | Decoded device address |
| out_endpt | output | 4 | Decoded endpoint |
| out_max_len | output | 11 | Decoded maximum length |

## Verification
The bound checker watches properties on every cycle:
- the one-cycle latency;
- inactive descriptors passing through unchanged;
- process error always pairing with abort and an unchanged word;
- isochronous select never leaving active set;
- an expired counter always showing timeout, a zero counter and active clear;
- a newly set babble bit always coming with stall and abort;
- the write-back flag matching the change in the word.

Only the bench scenarios can show the exact numbers: the length field value, the counter step, the short-packet boundary at exactly the maximum, the clipping threshold, the setup-only NAK retry, and the wrap of the maximum-length field.

// File: rtl/tdsu_pkg.sv
package tdsu_pkg;
   localparam int CW      = 32;
   localparam int LEN_W   = 11;
   localparam int ERR_W   = 2;

   localparam int B_SPD   = 29;
   localparam int B_ERRLO = 27;
   localparam int B_ISO   = 25;
   localparam int B_IOC   = 24;
   localparam int B_ACT   = 23;
   localparam int B_STALL = 22;
   localparam int B_BABB  = 20;
   localparam int B_NAK   = 19;
   localparam int B_TOUT  = 18;

   localparam logic [7:0] PID_SETUP = 8'h2D;
   localparam logic [7:0] PID_IN    = 8'h69;
   localparam logic [7:0] PID_OUT   = 8'hE1;

   typedef enum logic [2:0] {
      OC_DATA   = 3'd0,
      OC_NAK    = 3'd1,
      OC_STALL  = 3'd2,
      OC_NODEV  = 3'd3,
      OC_BABBLE = 3'd4
   } outcome_e;

   typedef enum logic [1:0] {
      VD_SUCCESS = 2'd0,
      VD_SKIP    = 2'd1,
      VD_ABORT   = 2'd2
   } verdict_e;

   typedef struct packed {
      logic [CW-1:0] ctrl;
      logic          wb;
      logic [1:0]    cause;
      logic          perr;
      logic          err_irq;
      logic [1:0]    verdict;
      logic [7:0]    pid;
      logic [6:0]    addr;
      logic [3:0]    ep;
      logic [LEN_W-1:0] max_len;
   } result_t;
endpackage

// File: rtl/tdsu_token_dec.sv
module tdsu_token_dec
   import tdsu_pkg::*;
(
   input  logic [CW-1:0]    token,
   output logic [7:0]       pid,
   output logic [6:0]       addr,
   output logic [3:0]       ep,
   output logic [LEN_W-1:0] max_len,
   output logic             pid_ok,
   output logic             is_in,
   output logic             is_setup
);
   localparam int ML_LO = CW - LEN_W;

   always_comb begin
      pid      = token[7:0];
      addr     = token[14:8];
      ep       = token[18:15];
      max_len  = token[CW-1:ML_LO] + LEN_W'(1);
      is_in    = (pid == PID_IN);
      is_setup = (pid == PID_SETUP);
      pid_ok   = is_in || is_setup || (pid == PID_OUT);
   end
endmodule

// File: rtl/tdsu_retry.sv
module tdsu_retry #(
   parameter int W = 2
) (
   input  logic [W-1:0] cnt_in,
   output logic [W-1:0] cnt_out,
   output logic         expired
);
   always_comb begin
      if (cnt_in == '0) begin
         cnt_out = '0;
         expired = 1'b0;
      end else begin
         cnt_out = cnt_in - W'(1);
         expired = (cnt_in == W'(1));
      end
   end
endmodule

// File: rtl/tdsu_rewrite.sv
module tdsu_rewrite
   import tdsu_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic [CW-1:0]    ctrl,
   input  logic [LEN_W-1:0] max_len,
   input  logic             pid_ok,
   input  logic             is_in,
   input  logic             is_setup,
   input  logic [2:0]       outcome,
   input  logic [CNT_W-1:0] count,
   output logic [CW-1:0]    new_ctrl,
   output logic [1:0]       cause,
   output logic             perr,
   output logic             err_irq,
   output logic [1:0]       verdict
);
   localparam int ERR_HI = B_ERRLO + ERR_W - 1;

   logic [CNT_W-1:0] ml_ext;
   logic             over;
   logic [LEN_W-1:0] len;
   logic [ERR_W-1:0] err_next;
   logic             err_exp;

   tdsu_retry #(.W(ERR_W)) u_retry (
      .cnt_in (ctrl[ERR_HI:B_ERRLO]),
      .cnt_out(err_next),
      .expired(err_exp)
   );

   always_comb begin
      ml_ext = CNT_W'(max_len);
      over   = is_in && (count > ml_ext);
      len    = is_in ? count[LEN_W-1:0] : max_len;
   end

   always_comb begin
      logic tmo;
      new_ctrl = ctrl;
      cause    = {1'b0, ctrl[B_IOC]};
      perr     = 1'b0;
      err_irq  = 1'b0;
      verdict  = VD_SKIP;
      tmo      = 1'b0;
      if (ctrl[B_ACT]) begin
         if (!pid_ok) begin
            perr    = 1'b1;
            verdict = VD_ABORT;
         end else begin
            if (ctrl[B_ISO]) new_ctrl[B_ACT] = 1'b0;
            if ((outcome == OC_DATA) && over) begin
               new_ctrl[B_BABB]  = 1'b1;
               new_ctrl[B_STALL] = 1'b1;
               new_ctrl[B_ACT]   = 1'b0;
               verdict           = VD_ABORT;
            end else begin
               case (outcome)
                  OC_DATA: begin
                     new_ctrl[LEN_W-1:0] = len - LEN_W'(1);
                     new_ctrl[B_ACT]     = 1'b0;
                     if (is_in && ctrl[B_SPD] && (len < max_len)) begin
                        cause[1] = 1'b1;
                        verdict  = VD_SKIP;
                     end else begin
                        verdict  = VD_SUCCESS;
                     end
                  end
                  OC_NAK: begin
                     new_ctrl[B_NAK] = 1'b1;
                     tmo             = is_setup;
                  end
                  OC_STALL: begin
                     new_ctrl[B_STALL] = 1'b1;
                     new_ctrl[B_ACT]   = 1'b0;
                  end
                  OC_BABBLE: begin
                     new_ctrl[B_BABB]  = 1'b1;
                     new_ctrl[B_STALL] = 1'b1;
                     new_ctrl[B_ACT]   = 1'b0;
                     verdict           = VD_ABORT;
                  end
                  default: tmo = 1'b1;
               endcase
               if (tmo) begin
                  new_ctrl[B_TOUT]         = 1'b1;
                  new_ctrl[ERR_HI:B_ERRLO] = err_next;
                  if (err_exp) begin
                     new_ctrl[B_ACT] = 1'b0;
                     err_irq         = 1'b1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/td_status_update.sv
module td_status_update
   import tdsu_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int REG_OUT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      in_ctrl,
   input  logic [31:0]      in_token,
   input  logic [2:0]       in_outcome,
   input  logic [CNT_W-1:0] in_count,
   output logic             out_valid,
   output logic [31:0]      out_ctrl,
   output logic             out_wb_need,
   output logic [1:0]       out_cause,
   output logic             out_perr,
   output logic             out_err_irq,
   output logic [1:0]       out_verdict,
   output logic [7:0]       out_pid,
   output logic [6:0]       out_dev_addr,
   output logic [3:0]       out_endpt,
   output logic [10:0]      out_max_len
);
   generate
      if (CNT_W < LEN_W) begin : g_bad_cnt
         $error("CNT_W must hold the largest transfer length");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("REG_OUT must be 0 or 1");
      end
   endgenerate

   logic             pid_ok, is_in, is_setup;
   logic [CW-1:0]    nctrl;
   result_t          nxt, cur;

   tdsu_token_dec u_dec (
      .token   (in_token),
      .pid     (nxt.pid),
      .addr    (nxt.addr),
      .ep      (nxt.ep),
      .max_len (nxt.max_len),
      .pid_ok  (pid_ok),
      .is_in   (is_in),
      .is_setup(is_setup)
   );

   tdsu_rewrite #(.CNT_W(CNT_W)) u_rw (
      .ctrl    (in_ctrl),
      .max_len (nxt.max_len),
      .pid_ok  (pid_ok),
      .is_in   (is_in),
      .is_setup(is_setup),
      .outcome (in_outcome),
      .count   (in_count),
      .new_ctrl(nctrl),
      .cause   (nxt.cause),
      .perr    (nxt.perr),
      .err_irq (nxt.err_irq),
      .verdict (nxt.verdict)
   );

   always_comb begin
      nxt.ctrl = nctrl;
      nxt.wb   = (nctrl != in_ctrl);
   end

   generate
      if (REG_OUT == 1) begin : g_reg
         logic vld_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               cur   <= '0;
            end else begin
               vld_q <= in_valid;
               cur   <= in_valid ? nxt : '0;
            end
         end
         assign out_valid = vld_q;
      end else begin : g_comb
         assign cur       = in_valid ? nxt : '0;
         assign out_valid = in_valid;
      end
   endgenerate

   assign out_ctrl     = cur.ctrl;
   assign out_wb_need  = cur.wb;
   assign out_cause    = cur.cause;
   assign out_perr     = cur.perr;
   assign out_err_irq  = cur.err_irq;
   assign out_verdict  = cur.verdict;
   assign out_pid      = cur.pid;
   assign out_dev_addr = cur.addr;
   assign out_endpt    = cur.ep;
   assign out_max_len  = cur.max_len;
endmodule

// File: rtl/tdsu_checker.sv
module tdsu_checker
   import tdsu_pkg::*;
#(
   parameter int LAT = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_ctrl,
   input logic        out_valid,
   input logic [31:0] out_ctrl,
   input logic        out_wb_need,
   input logic        out_perr,
   input logic        out_err_irq,
   input logic [1:0]  out_verdict
);
   generate
      if (LAT == 1) begin : g_seq
         assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
         assert_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && !in_ctrl[B_ACT] |=> out_ctrl == $past(in_ctrl)
               && out_verdict == VD_SKIP && !out_wb_need);
         assert_iso_R11: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ctrl[B_ISO] |=> !out_ctrl[B_ACT]
               || out_perr || out_ctrl == $past(in_ctrl));
         assert_wb_R12: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_wb_need == (out_ctrl != $past(in_ctrl)));
         assert_babble_R10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_ctrl[B_BABB] && !$past(in_ctrl[B_BABB])
               |-> out_ctrl[B_STALL] && !out_ctrl[B_ACT] && out_verdict == VD_ABORT);
      end
   endgenerate

   assert_perr_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_perr |-> out_verdict == VD_ABORT && !out_wb_need);
   assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err_irq |-> !out_ctrl[B_ACT] && out_ctrl[B_TOUT]
         && out_ctrl[B_ERRLO+1:B_ERRLO] == 2'd0);
endmodule

bind td_status_update tdsu_checker #(.LAT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ctrl    (in_ctrl),
   .out_valid  (out_valid),
   .out_ctrl   (out_ctrl),
   .out_wb_need(out_wb_need),
   .out_perr   (out_perr),
   .out_err_irq(out_err_irq),
   .out_verdict(out_verdict)
);

// File: tb/sim_td_status_update.sv
module sim_td_status_update;
   localparam int CNT_W = 12;

   typedef struct {
      logic [31:0] ctrl;
      logic        wb;
      logic [1:0]  cause;
      logic        perr;
      logic        eirq;
      logic [1:0]  vd;
      logic [7:0]  pid;
      logic [6:0]  addr;
      logic [3:0]  ep;
      logic [10:0] ml;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [31:0] in_ctrl = '0, in_token = '0;
   logic [2:0]  in_outcome = '0;
   logic [CNT_W-1:0] in_count = '0;
   logic out_valid, out_wb_need, out_perr, out_err_irq;
   logic [31:0] out_ctrl;
   logic [1:0]  out_cause, out_verdict;
   logic [7:0]  out_pid;
   logic [6:0]  out_dev_addr;
   logic [3:0]  out_endpt;
   logic [10:0] out_max_len;

   int checks = 0, fails = 0, pushed = 0, popped = 0;
   exp_t sb[$];
   bit finished = 0;

   always #2.5 clk = ~clk;

   td_status_update #(.CNT_W(CNT_W), .REG_OUT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
      .in_token(in_token), .in_outcome(in_outcome), .in_count(in_count),
      .out_valid(out_valid), .out_ctrl(out_ctrl), .out_wb_need(out_wb_need),
      .out_cause(out_cause), .out_perr(out_perr), .out_err_irq(out_err_irq),
      .out_verdict(out_verdict), .out_pid(out_pid), .out_dev_addr(out_dev_addr),
      .out_endpt(out_endpt), .out_max_len(out_max_len));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] tok(logic [7:0] pid, logic [6:0] a,
                                       logic [3:0] ep, logic [10:0] mf);
      return {mf, 2'b00, ep, a, pid};
   endfunction

   // reference model written from the requirement list
   function automatic exp_t model(logic [31:0] c, logic [31:0] t, logic [2:0] oc,
                                  logic [CNT_W-1:0] cnt, string tag);
      exp_t e;
      logic [10:0] ml, len;
      logic [31:0] nw;
      logic [1:0] err;
      logic in_p, set_p, to;
      int o;
      e.pid = t[7:0]; e.addr = t[14:8]; e.ep = t[18:15];
      ml = t[31:21] + 11'd1; e.ml = ml;
      e.cause = {1'b0, c[24]}; e.perr = 0; e.eirq = 0; e.vd = 2'd1; e.tag = tag;
      nw = c;
      in_p = (t[7:0] == 8'h69); set_p = (t[7:0] == 8'h2D);
      if (c[23]) begin
         if (!(in_p || set_p || t[7:0] == 8'hE1)) begin
            e.perr = 1; e.vd = 2'd2;
         end else begin
            o = int'(oc); to = 0;
            len = in_p ? cnt[10:0] : ml;
            if (in_p && oc == 3'd0 && int'(cnt) > int'(ml)) o = 4;
            if (c[25]) nw[23] = 0;
            case (o)
               0: begin
                  nw[10:0] = len - 11'd1; nw[23] = 0;
                  if (in_p && c[29] && len < ml) begin e.cause[1] = 1; e.vd = 2'd1; end
                  else e.vd = 2'd0;
               end
               1: begin nw[19] = 1; to = set_p; end
               2: begin nw[22] = 1; nw[23] = 0; end
               4: begin nw[20] = 1; nw[22] = 1; nw[23] = 0; e.vd = 2'd2; end
               default: to = 1;
            endcase
            if (to) begin
               nw[18] = 1; err = c[28:27];
               if (err != 0) begin
                  err = err - 1;
                  if (err == 0) begin nw[23] = 0; e.eirq = 1; end
               end
               nw[28:27] = err;
            end
         end
      end
      e.ctrl = nw; e.wb = (nw != c);
      return e;
   endfunction

   task automatic drive(logic [31:0] c, logic [31:0] t, logic [2:0] oc,
                        logic [CNT_W-1:0] cnt, string tag);
      @(negedge clk);
      in_valid = 1; in_ctrl = c; in_token = t; in_outcome = oc; in_count = cnt;
      sb.push_back(model(c, t, oc, cnt, tag));
      pushed++;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0; in_ctrl = '0; in_token = '0; in_outcome = '0; in_count = '0;
      end
   endtask

   // monitor: pops the scoreboard as results appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
               chk("R13", 32'd1, 32'd0, "unexpected out_valid");
            end else begin
               e = sb.pop_front();
               popped++;
               chk(e.tag, out_ctrl, e.ctrl, "ctrl");
               chk(e.tag, 32'(out_verdict), 32'(e.vd), "verdict");
               chk(e.tag, {out_cause, out_perr, out_err_irq}, {e.cause, e.perr, e.eirq}, "cause/perr/eirq");
               chk("R12", 32'(out_wb_need), 32'(e.wb), "write-back");
               chk("R1", {out_pid, out_dev_addr, out_endpt, out_max_len},
                   {e.pid, e.addr, e.ep, e.ml}, "decode");
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R13 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   localparam logic [31:0] ACT = 32'h0080_0000, IOC = 32'h0100_0000,
                           ISO = 32'h0200_0000, SPD = 32'h2000_0000;
   function automatic logic [31:0] ec(int n); return 32'(n) << 27; endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R13", {out_valid, out_ctrl, out_verdict, out_cause}, '0, "reset state");
      rst_n = 1;
      idle(1);
      drive(ACT | ec(3), tok(8'hE1, 7'h15, 4'd3, 11'd7), 3'd0, 12'd0, "R4 out data");
      drive(ACT | ec(3), tok(8'h69, 7'h01, 4'd1, 11'd7), 3'd0, 12'd8, "R4 in full");
      drive(ACT | SPD | IOC, tok(8'h69, 7'h02, 4'd2, 11'd7), 3'd0, 12'd3, "R5 short");
      drive(ACT | SPD, tok(8'h69, 7'h02, 4'd2, 11'd7), 3'd0, 12'd8, "R5 not short");
      drive(ACT, tok(8'h69, 7'h02, 4'd2, 11'd7), 3'd0, 12'd3, "R4 short no spd");
      idle(2);
      drive(ACT | ec(2), tok(8'h69, 7'h03, 4'd0, 11'd7), 3'd0, 12'd20, "R6 clip");
      drive(ACT | ec(3), tok(8'hE1, 7'h04, 4'd5, 11'd63), 3'd3, 12'd0, "R7 err 3");
      drive(ACT | ec(1), tok(8'hE1, 7'h04, 4'd5, 11'd63), 3'd3, 12'd0, "R7 expire");
      drive(ACT | ec(0), tok(8'hE1, 7'h04, 4'd5, 11'd63), 3'd6, 12'd0, "R7 zero");
      drive(ACT | ec(2), tok(8'h69, 7'h05, 4'd1, 11'd7), 3'd1, 12'd0, "R8 nak in");
      drive(ACT | ec(2), tok(8'h2D, 7'h05, 4'd0, 11'd7), 3'd1, 12'd0, "R8 nak setup");
      drive(ACT | ec(1), tok(8'h2D, 7'h05, 4'd0, 11'd7), 3'd1, 12'd0, "R8 setup expire");
      drive(ACT | ec(3), tok(8'h69, 7'h06, 4'd2, 11'd7), 3'd2, 12'd0, "R9 stall");
      drive(ACT | ec(3), tok(8'hE1, 7'h06, 4'd2, 11'd7), 3'd4, 12'd0, "R10 babble");
      idle(1);
      drive(IOC | ec(3), tok(8'h69, 7'h07, 4'd3, 11'd7), 3'd3, 12'd0, "R2 inactive");
      drive(ACT | IOC, tok(8'h55, 7'h07, 4'd3, 11'd7), 3'd0, 12'd0, "R3 bad pid");
      drive(ACT | ISO, tok(8'h69, 7'h08, 4'd4, 11'd7), 3'd1, 12'd0, "R11 iso nak");
      drive(ACT | ISO | ec(3), tok(8'hE1, 7'h08, 4'd4, 11'd7), 3'd3, 12'd0, "R11 iso tmo");
      drive(ACT | 32'h0008_0000, tok(8'h69, 7'h09, 4'd6, 11'd7), 3'd1, 12'd0, "R12 no change");
      drive(ACT | ec(3), tok(8'hE1, 7'h7F, 4'd15, 11'h7FF), 3'd0, 12'd0, "R1 null length");
      drive(ACT | ec(3), tok(8'h69, 7'h0A, 4'd7, 11'h7FF), 3'd0, 12'd0, "R4 in zero len");
      drive(ACT, tok(8'h69, 7'h0B, 4'd8, 11'd1023), 3'd0, 12'd1024, "R4 in 1024");
      drive(ACT, tok(8'h69, 7'h0B, 4'd8, 11'd1023), 3'd0, 12'd1025, "R6 one over");
      idle(3);
      chk("R13", 32'(popped), 32'(pushed), "results delivered");
      chk("R13", 32'(out_valid), 32'd0, "idle out_valid");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule